// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel digital-to-analog converter that is written over a parallel bus. The pins arrive asynchronously: an active-low select, an active-low write strobe, one address bit, a data word, gain and reference-buffer options, an active-low load strobe, an active-low clear and an active-low power-down. All of them are resampled in the system clock domain. Strobe edges are found there, and two register stages are kept for each channel.

A write lands in the staging register of the addressed channel. The converter-facing register of each channel changes only while the load strobe is low, and a low load copies both staging registers at once. The load can be held low across a write, so the new word goes straight through. It can also be pulsed later, so that both outputs move together. Clear and reset force every register to zero. Power-down is passed on as a flag and leaves the stored values untouched.

Top module: `dual_dac_regfile`

## Requirements
- R1: A word is accepted on the rising edge of `wr_n` only if `cs_n` was low in the last sample before that edge; a strobe with `cs_n` high changes nothing.
- R2: `addr`=0 writes the staging register of channel A and `addr`=1 writes that of channel B; the other channel's staging register keeps its value.
- R3: `gain_in` and `buf_in` are stored together with the data word and reach `a_gain`/`a_buf` or `b_gain`/`b_buf` along with the code.
- R4: While `load_n` is high, writes never change `a_code`, `b_code` or their option bits.
- R5: While `load_n` is low, both converter registers are loaded from their staging registers on the same clock edge.
- R6: With `load_n` held low across a write, the addressed output shows the new word on the same edge that stores it in the staging register.
- R7: A `load_n` pulse that comes after a completed write moves the stored word to the output; the write alone does not.
- R8: A low `clr_n` forces all staging and converter registers to zero and wins over a write or load at the same time.
- R9: Synchronous active-high `rst` sets all registers to zero and `pwr_down` to 0.
- R10: `pwr_down` reports an inverted `pd_n`; power-down neither alters stored codes nor blocks writes and loads.
- R11: A pin edge takes effect on the third rising clock edge after it and has no visible effect after two; a low pulse two clock periods wide is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Bus select, active low |
| wr_n | input | 1 | Write strobe, word taken on rising edge |
| addr | input | 1 | Channel select, 0 = A, 1 = B |
| data_in | input | 12 | Data word |
| gain_in | input | 1 | Output-range option stored with the word |
| buf_in | input | 1 | Reference-buffer option stored with the word |
| load_n | input | 1 | Transfer strobe, active low, level sensitive |
| clr_n | input | 1 | Clear, active low |
| pd_n | input | 1 | Power-down request, active low |
| a_code | output | 12 | Channel A converter code |
| a_gain | output | 1 | Channel A gain option |
| a_buf | output | 1 | Channel A buffer option |
| b_code | output | 12 | Channel B converter code |
| b_gain | output | 1 | Channel B gain option |
| b_buf | output | 1 | Channel B buffer option |
| pwr_down | output | 1 | Both channels powered down |

## Verification
The staging registers cannot be seen at the ports. A write that was dropped and a write to the wrong channel look the same until a later load. The stimulus therefore loads the other channel's staged value after each single-channel write, and loads again after a clear, to show that the hidden stage was emptied too. The synchronous-load case is also hard to reach: holding the load low before the write copies the other channel's stale staged word. The vector table orders its steps so that this side effect shows up as a change on the non-addressed output.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    localparam int CODE_W = 12;
    localparam int NUM_CH = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              gain;
        logic              buf_en;
    } chan_cfg_t;

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic              load_n;
        logic              clr_n;
        logic              pd_n;
        logic              sel;
        logic              gain;
        logic              buf_en;
        logic [CODE_W-1:0] data;
    } pin_bus_t;

    localparam int PIN_W = $bits(pin_bus_t);

    function automatic pin_bus_t pins_idle();
        pin_bus_t p;
        p        = '0;
        p.cs_n   = 1'b1;
        p.wr_n   = 1'b1;
        p.load_n = 1'b1;
        p.clr_n  = 1'b1;
        p.pd_n   = 1'b1;
        return p;
    endfunction

    function automatic chan_cfg_t cfg_from_pins(pin_bus_t p);
        chan_cfg_t c;
        c.code   = p.data;
        c.gain   = p.gain;
        c.buf_en = p.buf_en;
        return c;
    endfunction

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] now_q,
    output logic [WIDTH-1:0] prev_q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= pins;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= chain[STAGES-1];
    end

    assign now_q = chain[STAGES-1];
endmodule

// File: rtl/dac_strobe_decode.sv
module dac_strobe_decode
    import dac_if_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_bus_t  now_s,
    input  pin_bus_t  prev_s,
    output logic      wr_evt,
    output logic      wr_sel,
    output chan_cfg_t wr_word,
    output logic      load_act,
    output logic      clr_act,
    output logic      pd_act
);
    logic pd_q;

    always_comb begin
        clr_act  = ~now_s.clr_n;
        load_act = ~now_s.load_n & ~clr_act;
        // a write completes when the strobe rises; select, address and
        // word are taken from the last sample while the strobe was low
        wr_evt   = now_s.wr_n & ~prev_s.wr_n & ~prev_s.cs_n & ~clr_act;
        wr_sel   = prev_s.sel;
        wr_word  = cfg_from_pins(prev_s);
    end

    always_ff @(posedge clk) begin
        if (rst) pd_q <= 1'b0;
        else     pd_q <= ~now_s.pd_n;
    end

    assign pd_act = pd_q;
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
    import dac_if_pkg::*;
#(
    parameter logic CH_SEL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_evt,
    input  logic      wr_sel,
    input  chan_cfg_t wr_word,
    input  logic      load_act,
    input  logic      clr_act,
    output chan_cfg_t stage_q,
    output chan_cfg_t out_q
);
    chan_cfg_t stage_nxt;

    always_comb begin
        stage_nxt = stage_q;
        if (wr_evt && (wr_sel == CH_SEL)) stage_nxt = wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_act) begin
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            stage_q <= stage_nxt;
            if (load_act) out_q <= stage_nxt;
        end
    end
endmodule

// File: rtl/dual_dac_regfile.sv
module dual_dac_regfile
    import dac_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              addr,
    input  logic [CODE_W-1:0] data_in,
    input  logic              gain_in,
    input  logic              buf_in,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic              pd_n,
    output logic [CODE_W-1:0] a_code,
    output logic              a_gain,
    output logic              a_buf,
    output logic [CODE_W-1:0] b_code,
    output logic              b_gain,
    output logic              b_buf,
    output logic              pwr_down
);
    localparam pin_bus_t IDLE = pins_idle();

    pin_bus_t  raw_pins;
    pin_bus_t  now_s;
    pin_bus_t  prev_s;
    logic      wr_evt;
    logic      wr_sel;
    chan_cfg_t wr_word;
    logic      load_act;
    logic      clr_act;
    logic      pd_act;
    chan_cfg_t stage_q [NUM_CH];
    chan_cfg_t out_q   [NUM_CH];

    always_comb begin
        raw_pins.cs_n   = cs_n;
        raw_pins.wr_n   = wr_n;
        raw_pins.load_n = load_n;
        raw_pins.clr_n  = clr_n;
        raw_pins.pd_n   = pd_n;
        raw_pins.sel    = addr;
        raw_pins.gain   = gain_in;
        raw_pins.buf_en = buf_in;
        raw_pins.data   = data_in;
    end

    dac_pin_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .pins  (raw_pins),
        .now_q (now_s),
        .prev_q(prev_s)
    );

    dac_strobe_decode dec_i (
        .clk     (clk),
        .rst     (rst),
        .now_s   (now_s),
        .prev_s  (prev_s),
        .wr_evt  (wr_evt),
        .wr_sel  (wr_sel),
        .wr_word (wr_word),
        .load_act(load_act),
        .clr_act (clr_act),
        .pd_act  (pd_act)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
            dac_chan_regs #(.CH_SEL(1'(ch))) regs_i (
                .clk     (clk),
                .rst     (rst),
                .wr_evt  (wr_evt),
                .wr_sel  (wr_sel),
                .wr_word (wr_word),
                .load_act(load_act),
                .clr_act (clr_act),
                .stage_q (stage_q[ch]),
                .out_q   (out_q[ch])
            );
        end
    endgenerate

    assign a_code   = out_q[0].code;
    assign a_gain   = out_q[0].gain;
    assign a_buf    = out_q[0].buf_en;
    assign b_code   = out_q[1].code;
    assign b_gain   = out_q[1].gain;
    assign b_buf    = out_q[1].buf_en;
    assign pwr_down = pd_act;
endmodule

// File: rtl/dual_dac_regfile_chk.sv
module dual_dac_regfile_chk
    import dac_if_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      wr_evt,
    input logic      load_act,
    input logic      clr_act,
    input chan_cfg_t stg_a,
    input chan_cfg_t stg_b,
    input chan_cfg_t out_a,
    input chan_cfg_t out_b
);
    assert_wr_single_R1: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> !wr_evt);

    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_evt && !clr_act) |=> ($stable(stg_a) && $stable(stg_b)));

    assert_one_chan_R2: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> ($stable(stg_a) || $stable(stg_b)));

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_act && !clr_act) |=> ($stable(out_a) && $stable(out_b)));

    assert_load_copy_R5: assert property (@(posedge clk) disable iff (rst)
        load_act |=> (out_a == stg_a && out_b == stg_b));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (stg_a == '0 && stg_b == '0 && out_a == '0 && out_b == '0));

    assert_reset_zero_R9: assert property (@(posedge clk)
        rst |=> (stg_a == '0 && stg_b == '0 && out_a == '0 && out_b == '0));
endmodule

bind dual_dac_regfile dual_dac_regfile_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_evt  (wr_evt),
    .load_act(load_act),
    .clr_act (clr_act),
    .stg_a   (stage_q[0]),
    .stg_b   (stage_q[1]),
    .out_a   (out_q[0]),
    .out_b   (out_q[1])
);

// File: tb/dual_dac_regfile_tb.sv
module dual_dac_regfile_tb_top;
    import dac_if_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              cs_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
    logic [CODE_W-1:0] data_in = '0;
    logic              gain_in = 1'b0, buf_in = 1'b0;
    logic              load_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
    logic [CODE_W-1:0] a_code, b_code;
    logic              a_gain, a_buf, b_gain, b_buf, pwr_down;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dual_dac_regfile dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .data_in(data_in), .gain_in(gain_in), .buf_in(buf_in),
        .load_n(load_n), .clr_n(clr_n), .pd_n(pd_n),
        .a_code(a_code), .a_gain(a_gain), .a_buf(a_buf),
        .b_code(b_code), .b_gain(b_gain), .b_buf(b_buf),
        .pwr_down(pwr_down)
    );

    // op: 0 = write with load high, 1 = load pulse, 2 = write with load held low
    typedef struct packed {
        logic [1:0]  op;
        logic        sel;
        logic [11:0] data;
        logic [11:0] exp_a;
        logic [11:0] exp_b;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 12'h123, 12'h000, 12'h000},
        '{2'd0, 1'b1, 12'h456, 12'h000, 12'h000},
        '{2'd1, 1'b0, 12'h000, 12'h123, 12'h456},
        '{2'd2, 1'b0, 12'hABC, 12'hABC, 12'h456},
        '{2'd0, 1'b1, 12'hFFF, 12'hABC, 12'h456},
        '{2'd2, 1'b0, 12'h001, 12'h001, 12'hFFF},
        '{2'd0, 1'b0, 12'h800, 12'h001, 12'hFFF},
        '{2'd1, 1'b0, 12'h000, 12'h800, 12'hFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic sel, input logic [11:0] d,
                             input logic g, input logic b, input logic cs_val);
        cs_n = cs_val; addr = sel; data_in = d; gain_in = g; buf_in = b;
        wr_n = 1'b0;
        wait_n(2);
        wr_n = 1'b1;
        wait_n(1);
        cs_n = 1'b1;
        wait_n(4);
    endtask

    task automatic load_pulse();
        load_n = 1'b0;
        wait_n(2);
        load_n = 1'b1;
        wait_n(4);
    endtask

    task automatic sync_write(input logic sel, input logic [11:0] d);
        load_n = 1'b0;
        wait_n(3);
        bus_write(sel, d, 1'b0, 1'b0, 1'b0);
        load_n = 1'b1;
        wait_n(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R9: reset state
        chk("R9 a_code", a_code, 0);
        chk("R9 b_code", b_code, 0);
        chk("R9 pwr_down", pwr_down, 0);

        // vector table: R2 R4 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            case (VECS[i].op)
                2'd0: bus_write(VECS[i].sel, VECS[i].data, 1'b0, 1'b0, 1'b0);
                2'd1: load_pulse();
                default: sync_write(VECS[i].sel, VECS[i].data);
            endcase
            chk($sformatf("R4/R5/R6/R7 vec%0d a", i), a_code, VECS[i].exp_a);
            chk($sformatf("R2/R6 vec%0d b", i), b_code, VECS[i].exp_b);
        end

        // R1: strobe with select high is ignored (staging untouched, seen via load)
        bus_write(1'b1, 12'h3C3, 1'b0, 1'b0, 1'b1);
        load_pulse();
        chk("R1 ignored write b", b_code, 12'hFFF);
        chk("R1 ignored write a", a_code, 12'h800);

        // R3: options stored with word
        bus_write(1'b0, 12'h0F0, 1'b1, 1'b1, 1'b0);
        chk("R4 options held before load", a_gain, 0);
        load_pulse();
        chk("R3 a_code", a_code, 12'h0F0);
        chk("R3 a_gain", a_gain, 1);
        chk("R3 a_buf", a_buf, 1);
        chk("R3 b_gain", b_gain, 0);

        // R11: latency, two-period strobe, load held low
        load_n = 1'b0;
        wait_n(4);
        cs_n = 1'b0; addr = 1'b1; data_in = 12'h5A5; gain_in = 1'b0; buf_in = 1'b0;
        wr_n = 1'b0;
        wait_n(2);
        wr_n = 1'b1;
        wait_n(2);
        chk("R11 not yet after two edges", b_code, 12'hFFF);
        wait_n(1);
        chk("R11 visible after three edges", b_code, 12'h5A5);
        cs_n = 1'b1;
        load_n = 1'b1;
        wait_n(4);

        // R10: power-down keeps contents, writes still work
        pd_n = 1'b0;
        wait_n(2);
        chk("R10 pd latency", pwr_down, 0);
        wait_n(1);
        chk("R10 pd on", pwr_down, 1);
        chk("R10 a kept", a_code, 12'h0F0);
        chk("R10 b kept", b_code, 12'h5A5);
        bus_write(1'b0, 12'h777, 1'b0, 1'b0, 1'b0);
        load_pulse();
        chk("R10 write during pd", a_code, 12'h777);
        pd_n = 1'b1;
        wait_n(4);
        chk("R10 pd off", pwr_down, 0);

        // R8: clear wins over load and write
        bus_write(1'b1, 12'h321, 1'b0, 1'b0, 1'b0);
        clr_n = 1'b0; load_n = 1'b0;
        cs_n = 1'b0; addr = 1'b1; data_in = 12'h999; wr_n = 1'b0;
        wait_n(2);
        wr_n = 1'b1;
        wait_n(4);
        chk("R8 a cleared", a_code, 0);
        chk("R8 b cleared", b_code, 0);
        cs_n = 1'b1; load_n = 1'b1;
        wait_n(2);
        clr_n = 1'b1;
        wait_n(4);
        load_pulse();
        chk("R8 staging cleared a", a_code, 0);
        chk("R8 staging cleared b", b_code, 0);

        // R9: reset mid-run
        bus_write(1'b0, 12'h444, 1'b1, 1'b0, 1'b0);
        load_pulse();
        chk("R5 before reset", a_code, 12'h444);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
        chk("R9 reset a", a_code, 0);
        chk("R9 reset gain", a_gain, 0);
        load_pulse();
        chk("R9 staging reset", a_code, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule